// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that keeps a small bank of byte-wide configuration registers. Each bit of the bank is the enable for one clock output of the surrounding chip. After reset the bank holds fixed defaults, so the outputs run without any bus traffic. A bus master can later rewrite or inspect the bank one indexed byte at a time, or as a sequential block.

The master first sends a command code. Bit 7 of the code picks indexed-byte access (1) or block access (0). For byte access, bits 4:0 carry the register offset. Bits 6:5 must match a pattern set by an external select pin, so two identical devices can sit on one bus address. A block transfer carries a byte count ahead of the data. Block data always walks the bank upward from offset 0.

SCL and the sampled SDA pass through a two-flop synchroniser into the system clock before any edge is detected. SDA is driven open-drain: the block only ever asserts a pull-low enable.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave answers the 7-bit address 0x69 when `addr_sel_i` is 0 and 0x6E when it is 1. Any other address gets no acknowledge, and the rest of that transaction is ignored.
- R2: A command byte with bit 7 = 1 selects indexed access. Bits 4:0 give the offset. A following write byte lands at that offset. A read after a repeated START returns the byte at that offset.
- R3: Command bits 6:5 must be 01 when `chip_sel_i` is 0 and 10 when it is 1. On a mismatch, the command byte and every later byte up to the next START or STOP are not acknowledged, and no register changes.
- R4: A block write (command bit 7 = 0, bits 4:0 = 0) takes a count byte, then data bytes that fill offsets 0, 1, 2 and so on, each shifted in MSB first. A STOP after any whole byte keeps every byte already received.
- R5: A block read (block command, then a repeated START with the read address) returns the count byte, equal to the number of registers, and then offsets 0, 1, 2 and so on. It keeps going while the master acknowledges and stops after the first master NACK.
- R6: After reset the bank holds register 0 = 0xFF, register 1 = 0x3F and register 2 = 0xFF. `clk_en_o[8*i+j]` is bit j of register i.
- R7: The slave pulls SDA low during the ninth clock after a matching address, after a matching command and after each written byte. During the ninth clock of a byte it sends, it leaves SDA released.
- R8: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START restarts address reception and keeps the command just received. A STOP discards that command, so a read addressed without a new command is not acknowledged.
- R9: Offsets at or above the register count read back 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Sampled level of the serial data line |
| sda_oe_o | output | 1 | When 1, the serial data line is pulled low |
| addr_sel_i | input | 1 | Picks which of the two bus addresses is answered |
| chip_sel_i | input | 1 | Sets the pattern that command bits 6:5 must match |
| clk_en_o | output | NUM_REGS*8 | Register bank contents, one enable per bit |

## Verification
A STOP can arrive while the slave still holds or has just released SDA. A register write can land in the same system-clock cycle as the acknowledge drive that answers the same byte. The bench provokes both by ending transfers right after a data byte, and by sending a STOP mid-block. It then judges that the register value is already visible at the ports after the STOP and that the line reads released.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WCOUNT,
        ST_WDATA,
        ST_RCOUNT,
        ST_RDATA,
        ST_SKIP
    } stage_e;

    typedef struct packed {
        stage_e      stage;
        logic [3:0]  bit_cnt;
        logic [7:0]  shreg;
        logic        ack_ph;
        logic        sda_low;
        logic        byte_mode;
        logic        cmd_ok;
        logic [4:0]  offset;
    } slv_state_t;

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q, sync_q, prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
                prev_q <= 1'b1;
            end else begin
                meta_q <= async_i[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign sync_o[g] = sync_q;
        assign prev_o[g] = prev_q;
    end

endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank #(
    parameter int                    NUM_REGS  = 3,
    parameter int                    OFF_W     = 5,
    parameter logic [NUM_REGS*8-1:0] RESET_VAL = 24'hFF3FFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [OFF_W-1:0]      wr_addr_i,
    input  logic [7:0]            wr_data_i,
    input  logic [OFF_W-1:0]      rd_addr_i,
    output logic [7:0]            rd_data_o,
    output logic [NUM_REGS*8-1:0] regs_o
);

    logic [7:0] bank_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[g] <= RESET_VAL[g*8 +: 8];
            end else if (wr_en_i && (wr_addr_i == OFF_W'(g))) begin
                bank_q[g] <= wr_data_i;
            end
        end
        assign regs_o[g*8 +: 8] = bank_q[g];
    end

    always_comb begin
        rd_data_o = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr_i == OFF_W'(i)) begin
                rd_data_o = bank_q[i];
            end
        end
    end

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter int                    NUM_REGS  = 3,
    parameter logic [6:0]            ADDR_LOW  = 7'h69,
    parameter logic [6:0]            ADDR_HIGH = 7'h6E,
    parameter logic [NUM_REGS*8-1:0] RESET_VAL = 24'hFF3FFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic                  addr_sel_i,
    input  logic                  chip_sel_i,
    output logic [NUM_REGS*8-1:0] clk_en_o
);

    localparam int         OFF_W      = 5;
    localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);
    localparam logic [4:0] OFF_MAX    = 5'h1F;

    slv_state_t st_d, st_q;

    logic [1:0] sync2, prev2;
    logic       scl_s, sda_s, scl_p, sda_p;
    logic       scl_rise, scl_fall, start_evt, stop_evt;
    logic       wr_en;
    logic [7:0] rd_data, tx_byte;
    logic [6:0] my_addr;
    logic [1:0] cs_pat;
    logic       tx_stage;

    smb_sync #(.WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (sync2),
        .prev_o  (prev2)
    );

    assign scl_s     = sync2[1];
    assign sda_s     = sync2[0];
    assign scl_p     = prev2[1];
    assign sda_p     = prev2[0];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;

    smb_cfg_bank #(
        .NUM_REGS  (NUM_REGS),
        .OFF_W     (OFF_W),
        .RESET_VAL (RESET_VAL)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (st_q.offset),
        .wr_data_i (st_q.shreg),
        .rd_addr_i (st_q.offset),
        .rd_data_o (rd_data),
        .regs_o    (clk_en_o)
    );

    assign my_addr  = addr_sel_i ? ADDR_HIGH : ADDR_LOW;
    assign cs_pat   = chip_sel_i ? 2'b10 : 2'b01;
    assign tx_stage = (st_q.stage == ST_RCOUNT) || (st_q.stage == ST_RDATA);
    assign tx_byte  = (st_q.stage == ST_RCOUNT) ? COUNT_BYTE : rd_data;

    always_comb begin
        st_d  = st_q;
        wr_en = 1'b0;
        if (start_evt) begin
            st_d.stage   = ST_ADDR;
            st_d.bit_cnt = '0;
            st_d.ack_ph  = 1'b0;
            st_d.sda_low = 1'b0;
        end else if (stop_evt) begin
            st_d.stage   = ST_IDLE;
            st_d.bit_cnt = '0;
            st_d.ack_ph  = 1'b0;
            st_d.sda_low = 1'b0;
            st_d.cmd_ok  = 1'b0;
        end else if (st_q.stage != ST_IDLE && st_q.stage != ST_SKIP) begin
            if (scl_rise) begin
                if (!st_q.ack_ph) begin
                    st_d.bit_cnt = st_q.bit_cnt + 4'd1;
                    if (!tx_stage) begin
                        st_d.shreg = {st_q.shreg[6:0], sda_s};
                    end
                end else if (tx_stage && sda_s) begin
                    // master NACK ends the read
                    st_d.stage   = ST_SKIP;
                    st_d.ack_ph  = 1'b0;
                    st_d.sda_low = 1'b0;
                end
            end else if (scl_fall) begin
                if (st_q.ack_ph) begin
                    st_d.ack_ph  = 1'b0;
                    st_d.bit_cnt = '0;
                    st_d.sda_low = 1'b0;
                    if (tx_stage) begin
                        st_d.shreg   = tx_byte;
                        st_d.sda_low = ~tx_byte[7];
                    end
                end else if (st_q.bit_cnt == 4'd8) begin
                    st_d.ack_ph = 1'b1;
                    unique case (st_q.stage)
                        ST_ADDR: begin
                            if (st_q.shreg[7:1] == my_addr && (!st_q.shreg[0] || st_q.cmd_ok)) begin
                                st_d.sda_low = 1'b1;
                                if (!st_q.shreg[0]) st_d.stage = ST_CMD;
                                else if (st_q.byte_mode) st_d.stage = ST_RDATA;
                                else st_d.stage = ST_RCOUNT;
                            end else begin
                                st_d.stage  = ST_SKIP;
                                st_d.ack_ph = 1'b0;
                            end
                        end
                        ST_CMD: begin
                            if (st_q.shreg[6:5] == cs_pat) begin
                                st_d.cmd_ok    = 1'b1;
                                st_d.byte_mode = st_q.shreg[7];
                                st_d.offset    = st_q.shreg[7] ? st_q.shreg[4:0] : '0;
                                st_d.sda_low   = 1'b1;
                                st_d.stage     = st_q.shreg[7] ? ST_WDATA : ST_WCOUNT;
                            end else begin
                                st_d.cmd_ok = 1'b0;
                                st_d.stage  = ST_SKIP;
                                st_d.ack_ph = 1'b0;
                            end
                        end
                        ST_WCOUNT: begin
                            st_d.sda_low = 1'b1;
                            st_d.stage   = ST_WDATA;
                        end
                        ST_WDATA: begin
                            wr_en        = 1'b1;
                            st_d.sda_low = 1'b1;
                            st_d.offset  = (st_q.offset == OFF_MAX) ? OFF_MAX : st_q.offset + 5'd1;
                        end
                        ST_RCOUNT: begin
                            st_d.sda_low = 1'b0;
                            st_d.stage   = ST_RDATA;
                        end
                        ST_RDATA: begin
                            st_d.sda_low = 1'b0;
                            st_d.offset  = (st_q.offset == OFF_MAX) ? OFF_MAX : st_q.offset + 5'd1;
                        end
                        default: begin
                            st_d.ack_ph = 1'b0;
                        end
                    endcase
                end else if (tx_stage && st_q.bit_cnt != 4'd0) begin
                    st_d.sda_low = ~st_q.shreg[6];
                    st_d.shreg   = {st_q.shreg[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{stage: ST_IDLE, bit_cnt: '0, shreg: '0, ack_ph: 1'b0,
                      sda_low: 1'b0, byte_mode: 1'b0, cmd_ok: 1'b0, offset: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe_o = st_q.sda_low;

endmodule

// File: rtl/smb_cfg_checker.sv
module smb_cfg_checker #(
    parameter int REG_BITS = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scl_s,
    input logic                sda_oe,
    input logic                stop_evt,
    input logic                wr_en,
    input logic                cmd_ok,
    input logic [REG_BITS-1:0] clk_en
);

    // R7: the slave begins pulling SDA low only while the clock is low
    p_ack_drive_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R8: a STOP always leaves the line released
    p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    // R3: no register write without an accepted command
    p_write_needs_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> cmd_ok);

    // R4: enable outputs only move one cycle after a write strobe
    p_regs_change_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_en) |-> $past(wr_en));

endmodule

bind smb_cfg_slave smb_cfg_checker #(.REG_BITS(NUM_REGS*8)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe_o),
    .stop_evt (stop_evt),
    .wr_en    (wr_en),
    .cmd_ok   (st_q.cmd_ok),
    .clk_en   (clk_en_o)
);

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;

    localparam int HALF = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic        addr_sel = 1'b0;
    logic        chip_sel = 1'b0;
    logic        sda_oe;
    logic        sda;
    logic [23:0] clk_en;
    logic [23:0] exp_regs = 24'hFF3FFF;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    assign sda = ~(m_low | sda_oe);

    smb_cfg_slave i_smb_cfg_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda),
        .sda_oe_o   (sda_oe),
        .addr_sel_i (addr_sel),
        .chip_sel_i (chip_sel),
        .clk_en_o   (clk_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic pulse(output logic v);
        wait_h();
        scl = 1'b1;
        wait_h();
        v = sda;
        scl = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0;
        wait_h();
        scl = 1'b1;
        wait_h();
        m_low = 1'b1;
        wait_h();
        scl = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_stop();
        m_low = 1'b1;
        wait_h();
        scl = 1'b1;
        wait_h();
        m_low = 1'b0;
        wait_h();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i];
            pulse(v);
        end
        m_low = 1'b0;
        pulse(v);
        acked = (v == 1'b0);
    endtask

    task automatic recv_byte(input logic ack_low, output logic [7:0] b, output logic ninth);
        logic v;
        m_low = 1'b0;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            pulse(v);
            b = {b[6:0], v};
        end
        m_low = ack_low;
        pulse(ninth);
        m_low = 1'b0;
    endtask

    task automatic t_reset();
        chk("R6 reset defaults", 32'(clk_en), 32'h00FF3FFF);
        chk("R6 line released", 32'(sda_oe), 32'h0);
    endtask

    task automatic t_byte_access();
        logic a;
        logic [7:0] b;
        logic n;
        bus_start();
        send_byte(8'hD2, a); chk("R7 address ack", 32'(a), 32'h1);
        send_byte(8'hA1, a); chk("R7 command ack", 32'(a), 32'h1);
        send_byte(8'h5A, a); chk("R7 data ack", 32'(a), 32'h1);
        bus_stop();
        exp_regs[15:8] = 8'h5A;
        chk("R2 indexed write", 32'(clk_en), 32'(exp_regs));
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'hA1, a);
        bus_start();
        send_byte(8'hD3, a); chk("R8 repeated start read address ack", 32'(a), 32'h1);
        recv_byte(1'b0, b, n);
        chk("R2 indexed read", 32'(b), 32'h5A);
        chk("R7 released on read ninth clock", 32'(n), 32'h1);
        bus_stop();
    endtask

    task automatic t_addr_select();
        logic a;
        addr_sel = 1'b1;
        bus_start();
        send_byte(8'hD2, a); chk("R1 low address refused when select high", 32'(a), 32'h0);
        bus_stop();
        bus_start();
        send_byte(8'hDC, a); chk("R1 high address ack", 32'(a), 32'h1);
        send_byte(8'hA0, a);
        send_byte(8'hC3, a);
        bus_stop();
        exp_regs[7:0] = 8'hC3;
        chk("R1 write via high address", 32'(clk_en), 32'(exp_regs));
        addr_sel = 1'b0;
        bus_start();
        send_byte(8'hDC, a); chk("R1 high address refused when select low", 32'(a), 32'h0);
        bus_stop();
    endtask

    task automatic t_chip_select();
        logic a;
        chip_sel = 1'b1;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'hA1, a); chk("R3 mismatched command refused", 32'(a), 32'h0);
        send_byte(8'h99, a); chk("R3 data after mismatch refused", 32'(a), 32'h0);
        bus_stop();
        chk("R3 mismatch leaves bank", 32'(clk_en), 32'(exp_regs));
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'hC2, a); chk("R3 matching pattern 10 ack", 32'(a), 32'h1);
        send_byte(8'h11, a);
        bus_stop();
        exp_regs[23:16] = 8'h11;
        chk("R3 write with select high", 32'(clk_en), 32'(exp_regs));
        chip_sel = 1'b0;
    endtask

    task automatic t_block_write();
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h20, a); chk("R4 block command ack", 32'(a), 32'h1);
        send_byte(8'h03, a); chk("R4 count ack", 32'(a), 32'h1);
        send_byte(8'h01, a);
        send_byte(8'h02, a);
        bus_stop();
        exp_regs[7:0]  = 8'h01;
        exp_regs[15:8] = 8'h02;
        chk("R4 early stop keeps whole bytes", 32'(clk_en), 32'(exp_regs));
    endtask

    task automatic t_block_read();
        logic a;
        logic [7:0] b;
        logic n;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h20, a);
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(1'b1, b, n); chk("R5 count byte", 32'(b), 32'h3);
        recv_byte(1'b1, b, n); chk("R5 offset 0", 32'(b), 32'(exp_regs[7:0]));
        recv_byte(1'b1, b, n); chk("R5 offset 1", 32'(b), 32'(exp_regs[15:8]));
        recv_byte(1'b0, b, n); chk("R5 offset 2", 32'(b), 32'(exp_regs[23:16]));
        chk("R7 released after last read byte", 32'(n), 32'h1);
        bus_stop();
    endtask

    task automatic t_out_of_range();
        logic a;
        logic [7:0] b;
        logic n;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'hA5, a);
        send_byte(8'h77, a);
        bus_stop();
        chk("R9 write beyond bank ignored", 32'(clk_en), 32'(exp_regs));
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'hA5, a);
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(1'b0, b, n);
        chk("R9 read beyond bank", 32'(b), 32'h0);
        bus_stop();
    endtask

    task automatic t_stale_command();
        logic a;
        bus_start();
        send_byte(8'hD3, a); chk("R8 read after stop needs new command", 32'(a), 32'h0);
        bus_stop();
        chk("R8 bank unchanged", 32'(clk_en), 32'(exp_regs));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_byte_access();
        t_addr_select();
        t_chip_select();
        t_block_write();
        t_block_read();
        t_out_of_range();
        t_stale_command();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule